// File: doc/BRIEF.md
# Branch Trace Packet Recorder

The recorder watches the instruction address stream that the processor presents on a private trace port. When the program counter jumps instead of stepping to the next instruction (a taken branch or an exception entry), it forms a 64-bit packet and stores it as two 32-bit words in a RAM array. The first word holds the address the jump left from. The second word holds the address it landed on. Packets go into a circular window in that RAM. The window has a programmable base and a power-of-two size. A write pointer moves 8 bytes per packet and returns to the base when it passes the end of the window. A sticky flag records that the window has wrapped at least once.

The same RAM array also serves ordinary system bus reads and writes. A small two-input controller puts both sources onto the single RAM port. Trace writes always win. While a packet is being written, a bus access is held off by dropping its ready signal.

The writer has three states:
- `WR_IDLE`: no packet in progress.
- `WR_SRC`: writing the source word.
- `WR_DST`: writing the destination word.

Its transitions are:
- capture: `WR_IDLE` to `WR_SRC`, taken when a jump is detected while tracing is enabled.
- second word: `WR_SRC` to `WR_DST`, always taken.
- advance: `WR_DST` to `WR_IDLE`, always taken; the pointer moves on at this step.

Top module: `flow_trace_recorder`

## Requirements
- R1: After reset, tracing is disabled, `wr_ptr` equals `win_base`, `wrapped` is 0, `bus_ready` is 1, and the RAM port stays idle unless the bus requests it.
- R2: A new address is a sequential step, and makes no packet, when it equals the previous address plus 2 (previous `pc_wide` = 0) or plus 4 (previous `pc_wide` = 1). The first address after reset never makes a packet.
- R3: Any other new address, while enabled and idle, makes a packet. The RAM is written at `wr_ptr` in the next cycle and at `wr_ptr`+4 in the cycle after that. The source word holds the previous address and the destination word holds the new address.
- R4: Bit 0 of the source word equals `pc_exc` as sampled with the new address. A value of 1 marks a packet caused by exception entry.
- R5: Bit 0 of the destination word is 1 only for the first packet after tracing becomes enabled (including the first enable after reset), and 0 otherwise.
- R6: After each packet, `wr_ptr` moves on by 8 within a window of 2^`win_szlog` bytes (`win_szlog` ≥ 3). On reaching the window end it returns to `win_base` and sets `wrapped`. `wrapped` then stays set until reset.
- R7: During both trace write cycles, `bus_ready` is 0 and the bus request does not reach the RAM. A colliding bus access is therefore stalled for exactly two cycles.
- R8: When no packet is being written, a bus request is passed to the RAM in the same cycle. The RAM read data appears on `bus_rdata` one cycle after a read is accepted.
- R9: While `trace_en` is 0, jumps make no packet. A packet already in `WR_SRC` when `trace_en` falls still writes its second word and moves the pointer on.
- R10: A jump seen while a packet is being written is dropped. The address tracker still follows every address, so the next jump is judged against the latest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Trace enable |
| win_base | input | 32 | Trace window base, aligned to window size |
| win_szlog | input | 5 | log2 of window size in bytes |
| pc_valid | input | 1 | New instruction address present |
| pc_addr | input | 32 | Instruction address (halfword aligned) |
| pc_wide | input | 1 | Instruction at `pc_addr` is 4 bytes (else 2) |
| pc_exc | input | 1 | This address change is an exception entry |
| bus_req | input | 1 | System bus access request |
| bus_we | input | 1 | Bus write (else read) |
| bus_addr | input | 32 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, one cycle after acceptance |
| bus_ready | output | 1 | Bus access accepted this cycle |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 32 | RAM byte address |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM registered read data |
| wr_ptr | output | 32 | Current trace write address |
| wrapped | output | 1 | Window has wrapped at least once |

## Verification
Some behaviours are checked by assertions on every cycle:
- the `WR_SRC` to `WR_DST` pairing and the 4-byte step between the two word addresses;
- the stickiness of `wrapped`;
- that the writer stays idle while disabled;
- that the address tracker follows each valid address;
- that the bus is refused whenever the writer is busy.

Other behaviours show only in the bench's scenarios, which compare every RAM port cycle against a behavioural reference model:
- the packet contents with their exception and run-start flags;
- dropped jumps during a busy writer;
- completion of a packet after a mid-packet disable;
- the exact two-cycle bus stall;
- read data returning a cycle after acceptance.

// File: rtl/ftr_pkg.sv
package ftr_pkg;
    localparam int WORD_W    = 32;
    localparam int WORD_STEP = WORD_W / 8;
    localparam int PKT_STEP  = 2 * WORD_STEP;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_SRC,
        WR_DST
    } wr_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
    } trace_pkt_t;
endpackage

// File: rtl/ftr_flow_detect.sv
module ftr_flow_detect
    import ftr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pc_valid,
    input  logic [WORD_W-1:0] pc_addr,
    input  logic              pc_wide,
    output logic              nonseq,
    output logic [WORD_W-1:0] prev_pc
);
    logic              last_wide;
    logic              have_last;
    logic [WORD_W-1:0] seq_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pc   <= '0;
            last_wide <= 1'b0;
            have_last <= 1'b0;
        end else if (pc_valid) begin
            prev_pc   <= pc_addr;
            last_wide <= pc_wide;
            have_last <= 1'b1;
        end
    end

    always_comb begin
        seq_next = prev_pc + (last_wide ? WORD_W'(4) : WORD_W'(2));
        nonseq   = pc_valid && have_last && (pc_addr != seq_next);
    end

    assert_prev_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |=> (prev_pc == $past(pc_addr)));
endmodule

// File: rtl/ftr_pkt_writer.sv
module ftr_pkt_writer
    import ftr_pkg::*;
#(
    parameter int SZ_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              nonseq,
    input  logic              pc_exc,
    input  logic [WORD_W-1:0] prev_pc,
    input  logic [WORD_W-1:0] pc_addr,
    input  logic [WORD_W-1:0] win_base,
    input  logic [SZ_W-1:0]   win_szlog,
    output logic              trc_we,
    output logic [WORD_W-1:0] trc_addr,
    output logic [WORD_W-1:0] trc_wdata,
    output logic              busy,
    output logic [WORD_W-1:0] wr_ptr,
    output logic              wrapped
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

    wr_state_e         state, state_nx;
    trace_pkt_t        pkt;
    logic              run_start;
    logic              capture;
    logic [WORD_W-1:0] offset, offset_nx, win_mask;

    always_comb begin
        win_mask  = (ONE << win_szlog) - ONE;
        offset_nx = (offset + WORD_W'(PKT_STEP)) & win_mask;
        capture   = 1'b0;
        state_nx  = state;
        unique case (state)
            WR_IDLE: if (trace_en && nonseq) begin
                capture  = 1'b1;
                state_nx = WR_SRC;
            end
            WR_SRC:  state_nx = WR_DST;
            WR_DST:  state_nx = WR_IDLE;
            default: state_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt       <= '0;
            run_start <= 1'b1;
            offset    <= '0;
            wrapped   <= 1'b0;
        end else begin
            if (capture) begin
                pkt.src <= (prev_pc & ~ONE) | WORD_W'(pc_exc);
                pkt.dst <= (pc_addr & ~ONE) | WORD_W'(run_start);
            end
            if (!trace_en)    run_start <= 1'b1;
            else if (capture) run_start <= 1'b0;
            if (state == WR_DST) begin
                offset <= offset_nx;
                if (offset_nx == '0) wrapped <= 1'b1;
            end
        end
    end

    always_comb begin
        wr_ptr    = win_base + offset;
        trc_we    = 1'b0;
        trc_addr  = wr_ptr;
        trc_wdata = pkt.src;
        unique case (state)
            WR_IDLE: ;
            WR_SRC:  trc_we = 1'b1;
            WR_DST: begin
                trc_we    = 1'b1;
                trc_addr  = wr_ptr + WORD_W'(WORD_STEP);
                trc_wdata = pkt.dst;
            end
            default: ;
        endcase
        busy = trc_we;
    end

    assert_word_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_SRC) |=> (state == WR_DST));
    assert_word_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_SRC) |=> (trc_addr == $past(trc_addr) + WORD_W'(WORD_STEP)));
    assert_wrap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);
    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trace_en && state == WR_IDLE) |=> (state == WR_IDLE));
endmodule

// File: rtl/ftr_ram_arb.sv
module ftr_ram_arb
    import ftr_pkg::*;
(
    input  logic              trc_we,
    input  logic [WORD_W-1:0] trc_addr,
    input  logic [WORD_W-1:0] trc_wdata,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              ram_en,
    output logic              ram_we,
    output logic [WORD_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata
);
    always_comb begin
        bus_ready = !trc_we;
        if (trc_we) begin
            ram_en    = 1'b1;
            ram_we    = 1'b1;
            ram_addr  = trc_addr;
            ram_wdata = trc_wdata;
        end else begin
            ram_en    = bus_req;
            ram_we    = bus_req && bus_we;
            ram_addr  = bus_addr;
            ram_wdata = bus_wdata;
        end
    end
endmodule

// File: rtl/flow_trace_recorder.sv
module flow_trace_recorder
    import ftr_pkg::*;
#(
    parameter int SZ_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic [WORD_W-1:0] win_base,
    input  logic [SZ_W-1:0]   win_szlog,
    input  logic              pc_valid,
    input  logic [WORD_W-1:0] pc_addr,
    input  logic              pc_wide,
    input  logic              pc_exc,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic              ram_en,
    output logic              ram_we,
    output logic [WORD_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    input  logic [WORD_W-1:0] ram_rdata,
    output logic [WORD_W-1:0] wr_ptr,
    output logic              wrapped
);
    logic              nonseq, trc_we, busy;
    logic [WORD_W-1:0] prev_pc, trc_addr, trc_wdata;

    ftr_flow_detect u_detect (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc_addr(pc_addr),
        .pc_wide(pc_wide), .nonseq(nonseq), .prev_pc(prev_pc)
    );

    ftr_pkt_writer #(.SZ_W(SZ_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .nonseq(nonseq),
        .pc_exc(pc_exc), .prev_pc(prev_pc), .pc_addr(pc_addr),
        .win_base(win_base), .win_szlog(win_szlog), .trc_we(trc_we),
        .trc_addr(trc_addr), .trc_wdata(trc_wdata), .busy(busy),
        .wr_ptr(wr_ptr), .wrapped(wrapped)
    );

    ftr_ram_arb u_arb (
        .trc_we(trc_we), .trc_addr(trc_addr), .trc_wdata(trc_wdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .ram_en(ram_en),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    assign bus_rdata = ram_rdata;

    assert_bus_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!bus_ready && ram_we));
endmodule

// File: tb/test_flow_trace_recorder.sv
module test_flow_trace_recorder;
    logic        clk = 1'b0;
    logic        rst_n, trace_en, pc_valid, pc_wide, pc_exc;
    logic        bus_req, bus_we, bus_ready, ram_en, ram_we, wrapped;
    logic [4:0]  win_szlog;
    logic [31:0] win_base, pc_addr, bus_addr, bus_wdata, bus_rdata;
    logic [31:0] ram_addr, ram_wdata, ram_rdata, wr_ptr;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    flow_trace_recorder i_flow_trace_recorder (.*);

    // behavioural RAM, registered read
    logic [31:0] mem [0:63];
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr[7:2]] <= ram_wdata;
            else        ram_rdata <= mem[ram_addr[7:2]];
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model
    int          m_state;
    logic [31:0] m_last, m_src, m_dst, m_off;
    logic        m_wide, m_have, m_wrap, m_start;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_last = 0; m_wide = 0; m_have = 0;
            m_off = 0; m_wrap = 0; m_start = 1; m_src = 0; m_dst = 0;
        end else begin
            logic det, cap;
            logic [31:0] mask;
            mask = (32'd1 << win_szlog) - 1;
            det  = pc_valid && m_have && (pc_addr != m_last + (m_wide ? 4 : 2));
            cap  = 0;
            case (m_state)
                0: if (trace_en && det) begin
                    cap = 1;
                    m_src = {m_last[31:1], pc_exc};
                    m_dst = {pc_addr[31:1], m_start};
                    m_state = 1;
                end
                1: m_state = 2;
                default: begin
                    m_off = (m_off + 8) & mask;
                    if (m_off == 0) m_wrap = 1;
                    m_state = 0;
                end
            endcase
            if (!trace_en) m_start = 1;
            else if (cap)  m_start = 0;
            if (pc_valid) begin
                m_last = pc_addr; m_wide = pc_wide; m_have = 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            logic busy_m;
            busy_m = (m_state != 0);
            tag = busy_m ? (bus_req ? "R7" : "R3") : (bus_req ? "R8" : "R2");
            check({tag, " ram_en"}, 32'(ram_en), 32'(busy_m || bus_req));
            check({tag, " bus_ready"}, 32'(bus_ready), 32'(!busy_m));
            if (busy_m) begin
                check("R3 addr", ram_addr, win_base + m_off + (m_state == 2 ? 4 : 0));
                check("R3 data", ram_wdata, m_state == 2 ? m_dst : m_src);
                check("R3 we", 32'(ram_we), 32'd1);
            end else if (bus_req) begin
                check("R8 addr", ram_addr, bus_addr);
                check("R8 we", 32'(ram_we), 32'(bus_we));
            end
            check("R6 wr_ptr", wr_ptr, win_base + m_off);
            check("R6 wrapped", 32'(wrapped), 32'(m_wrap));
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic pc_step(logic [31:0] a, logic w, logic e);
        pc_valid = 1; pc_addr = a; pc_wide = w; pc_exc = e;
        cyc();
        pc_valid = 0; pc_exc = 0;
    endtask

    task automatic bus_access(logic we, logic [31:0] a, logic [31:0] d, output int stalls);
        logic ok;
        stalls = 0;
        bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        forever begin
            @(negedge clk); ok = bus_ready;
            cyc();
            if (ok) break;
            stalls++;
        end
        bus_req = 0; bus_we = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int st;
        rst_n = 0; trace_en = 0; win_base = 32'h80; win_szlog = 5;
        pc_valid = 0; pc_addr = 0; pc_wide = 0; pc_exc = 0;
        bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        for (int i = 0; i < 64; i++) mem[i] = 0;
        repeat (3) cyc();
        rst_n = 1;
        @(negedge clk);
        check("R1 wr_ptr", wr_ptr, 32'h80);
        check("R1 wrapped", 32'(wrapped), 0);
        check("R1 bus_ready", 32'(bus_ready), 1);
        check("R1 ram_en", 32'(ram_en), 0);
        cyc();

        trace_en = 1;
        // R2 sequential steps of both sizes
        pc_step(32'h100, 0, 0); pc_step(32'h102, 1, 0);
        pc_step(32'h106, 0, 0); pc_step(32'h108, 0, 0);
        repeat (3) cyc();
        check("R2 no packet", wr_ptr, 32'h80);

        // R3 / R5 branch, first packet of run
        pc_step(32'h200, 0, 0);
        repeat (3) cyc();
        check("R3 src word", mem[32], 32'h108);
        check("R5 dst start flag", mem[33], 32'h201);
        check("R6 ptr step", wr_ptr, 32'h88);

        // R4 exception entry
        pc_step(32'h202, 0, 0);
        pc_step(32'h40, 0, 1);
        repeat (3) cyc();
        check("R4 exc flag", mem[34], 32'h203);
        check("R5 no start flag", mem[35], 32'h40);

        // R10 jump while busy is dropped
        pc_step(32'h300, 0, 0);
        pc_step(32'h500, 0, 0);
        repeat (3) cyc();
        check("R10 one packet", wr_ptr, 32'h98);
        check("R10 dst", mem[37], 32'h300);
        pc_step(32'h600, 0, 0);
        repeat (3) cyc();
        check("R10 tracker src", mem[38], 32'h500);
        check("R6 wrap ptr", wr_ptr, 32'h80);
        check("R6 wrapped", 32'(wrapped), 1);

        // R9 disable mid-packet, then disabled jump
        pc_step(32'h700, 0, 0);
        trace_en = 0;
        repeat (3) cyc();
        check("R9 finished packet", wr_ptr, 32'h88);
        check("R9 dst word", mem[33], 32'h700);
        pc_step(32'h900, 0, 0);
        repeat (3) cyc();
        check("R9 no packet", wr_ptr, 32'h88);
        trace_en = 1;
        pc_step(32'hA00, 0, 0);
        repeat (3) cyc();
        check("R5 restart flag", mem[35], 32'hA01);

        // R8 bus access when idle
        bus_access(1, 32'h10, 32'hCAFE0001, st);
        check("R8 no stall", 32'(st), 0);
        bus_access(0, 32'h10, 0, st);
        @(negedge clk);
        check("R8 read data", bus_rdata, 32'hCAFE0001);
        cyc();

        // R7 collision stalls two cycles
        pc_step(32'hC00, 0, 0);
        bus_access(1, 32'h14, 32'h1234_5678, st);
        check("R7 stall cycles", 32'(st), 2);
        check("R7 trace kept", mem[37], 32'hC00 | 32'h0);
        bus_access(0, 32'h14, 0, st);
        @(negedge clk);
        check("R7 bus data", bus_rdata, 32'h1234_5678);
        cyc();
        finish_run();
    end
endmodule